// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block derives a panel pixel clock from one of two source tick streams that both run on a single fast clock. A 12-bit divide word carries an 8-bit integer part and a 4-bit fraction. A four-bit phase accumulator stretches some periods by one source tick, so the average period over sixteen periods is exactly the programmed ratio. Each period produces a one-cycle strobe for the downstream pixel pipeline and a level waveform for the panel pin.

Within each period, two 9-bit positions in half-tick units set where the level goes high and where it goes low, and so they set the duty cycle. An odd position lands on the next whole source tick. A polarity control can invert the pin level. Software works out the divide word and the edge positions. The block only applies them. The divide word and the edge positions are held in shadow registers, and new values are taken only when a new period starts. The source select and the polarity control take effect at once.

Top module: `pclk_frac_gen`

## Requirements
- R1: While reset is asserted and until the first selected source tick after it, pix_stb is 0 and the internal level is low, so pix_clk equals clk_invert.
- R2: When src_ext_sel is 1, only ext_tick advances the generator and int_tick has no effect. When src_ext_sel is 0, only int_tick advances it and ext_tick has no effect.
- R3: The divide word div_word carries its integer part I in bits [11:4] and its fraction F in bits [3:0]. Each period lasts I or I+1 selected ticks. A running fraction sum that starts at 0 on reset adds F once per period, and a period gets the extra tick exactly when that sum crosses a multiple of 16.
- R4: An integer part of 0 is treated as 1.
- R5: pix_stb is high for exactly the one clock cycle after a selected tick that starts a period, and is low in every other cycle. The first selected tick after reset starts a period.
- R6: At tick index k within a period (k=0 is the starting tick), the level is high exactly when 2k >= rise_pos and 2k < fall_pos. Positions are in half-tick units, so an odd position takes effect one half-step late, on the next whole tick.
- R7: With rise_pos 0 and fall_pos equal to I, the level is high for the first ceil(I/2) ticks of every period, which is a 50% duty cycle for even I.
- R8: Values of div_word, rise_pos and fall_pos are captured only at the tick that starts a period. A change made during a period has no effect until the next period starts.
- R9: pix_clk is the level XOR clk_invert, and a change of clk_invert is visible in the same cycle.
- R10: In a cycle with no selected tick, the level and the period position are unchanged and pix_stb is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that carries both source tick streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | One-cycle tick from the internal bus clock source |
| ext_tick | input | 1 | One-cycle tick from the external clock source |
| src_ext_sel | input | 1 | 1 selects ext_tick, 0 selects int_tick |
| clk_invert | input | 1 | Inverts the pixel clock pin level |
| div_word | input | 12 | Divide ratio, integer in [11:4], fraction in [3:0] |
| rise_pos | input | 9 | Rising edge position in half-tick units |
| fall_pos | input | 9 | Falling edge position in half-tick units |
| pix_stb | output | 1 | One-cycle strobe at the start of each pixel period |
| pix_clk | output | 1 | Pixel clock level for the panel |

## Verification
The assertions check on every cycle that a period-ending tick always raises the strobe, and that a cycle without a tick leaves the level unchanged and the strobe low. They also check that the edge and length shadows move only at a period boundary, and that the position stays inside a nonzero period length. Only the bench scenarios can show that the carry sequence gives the right sixteen-period total for each fraction, where odd edge positions land, and the integer-zero clamp. The same holds for ignoring the unselected source and for deferring a change made mid-period. For all of these the bench compares every cycle against an arithmetic model built from the requirements.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    localparam int unsigned PCLK_INT_W  = 8;
    localparam int unsigned PCLK_FRAC_W = 4;
    localparam int unsigned PCLK_POS_W  = 9;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } pclk_src_e;
endpackage

// File: rtl/pclk_src_sel.sv
module pclk_src_sel
    import pclk_pkg::*;
#(
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0] src_tick,
    input  pclk_src_e        src_sel,
    output logic             tick
);
    logic [N_SRC-1:0] gated;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign gated[g] = src_tick[g] && (int'(src_sel) == g);
    end

    assign tick = |gated;
endmodule

// File: rtl/pclk_frac_step.sv
module pclk_frac_step #(
    parameter int unsigned INT_W  = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  logic [INT_W+FRAC_W-1:0] div_word,
    input  logic [FRAC_W-1:0]       acc_cur,
    output logic [INT_W:0]          len_nxt,
    output logic [FRAC_W-1:0]       acc_nxt
);
    localparam int unsigned DIV_W = INT_W + FRAC_W;

    logic [INT_W-1:0]  int_part;
    logic [FRAC_W:0]   frac_sum;

    always_comb begin
        int_part = div_word[DIV_W-1:FRAC_W];
        if (int_part == '0) begin
            int_part = {{(INT_W-1){1'b0}}, 1'b1};
        end
        frac_sum = {1'b0, acc_cur} + {1'b0, div_word[FRAC_W-1:0]};
        acc_nxt  = frac_sum[FRAC_W-1:0];
        len_nxt  = {1'b0, int_part} + {{INT_W{1'b0}}, frac_sum[FRAC_W]};
    end
endmodule

// File: rtl/pclk_phase_cmp.sv
module pclk_phase_cmp #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned POS_W = 9
) (
    input  logic [IDX_W-1:0] tick_idx,
    input  logic [POS_W-1:0] rise_at,
    input  logic [POS_W-1:0] fall_at,
    output logic             level
);
    localparam int unsigned HS_W = (IDX_W + 1 > POS_W) ? IDX_W + 1 : POS_W;

    logic [HS_W-1:0] half_pos;
    logic [HS_W-1:0] rise_x;
    logic [HS_W-1:0] fall_x;

    always_comb begin
        half_pos = HS_W'({tick_idx, 1'b0});
        rise_x   = HS_W'(rise_at);
        fall_x   = HS_W'(fall_at);
        level    = (half_pos >= rise_x) && (half_pos < fall_x);
    end
endmodule

// File: rtl/pclk_frac_gen.sv
module pclk_frac_gen
    import pclk_pkg::*;
#(
    parameter int unsigned INT_W  = PCLK_INT_W,
    parameter int unsigned FRAC_W = PCLK_FRAC_W,
    parameter int unsigned POS_W  = PCLK_POS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    int_tick,
    input  logic                    ext_tick,
    input  logic                    src_ext_sel,
    input  logic                    clk_invert,
    input  logic [INT_W+FRAC_W-1:0] div_word,
    input  logic [POS_W-1:0]        rise_pos,
    input  logic [POS_W-1:0]        fall_pos,
    output logic                    pix_stb,
    output logic                    pix_clk
);
    localparam int unsigned LEN_W = INT_W + 1;
    localparam int unsigned CNT_W = INT_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [FRAC_W-1:0] acc;
        logic [POS_W-1:0]  rise;
        logic [POS_W-1:0]  fall;
        logic              lvl;
        logic              stb;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic              tick;
    logic              wrap;
    logic [LEN_W-1:0]  len_new;
    logic [FRAC_W-1:0] acc_new;
    logic [CNT_W-1:0]  idx_next;
    logic [POS_W-1:0]  rise_use;
    logic [POS_W-1:0]  fall_use;
    logic              lvl_new;

    pclk_src_sel #(.N_SRC(2)) i_src (
        .src_tick ({ext_tick, int_tick}),
        .src_sel  (pclk_src_e'(src_ext_sel)),
        .tick     (tick)
    );

    pclk_frac_step #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_step (
        .div_word (div_word),
        .acc_cur  (st_q.acc),
        .len_nxt  (len_new),
        .acc_nxt  (acc_new)
    );

    pclk_phase_cmp #(.IDX_W(CNT_W), .POS_W(POS_W)) i_cmp (
        .tick_idx (idx_next),
        .rise_at  (rise_use),
        .fall_at  (fall_use),
        .level    (lvl_new)
    );

    always_comb begin
        wrap     = ({1'b0, st_q.cnt} == (st_q.len - LEN_W'(1)));
        idx_next = wrap ? '0 : st_q.cnt + CNT_W'(1);
        rise_use = wrap ? rise_pos : st_q.rise;
        fall_use = wrap ? fall_pos : st_q.fall;
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (tick) begin
            st_d.cnt = idx_next;
            st_d.lvl = lvl_new;
            st_d.stb = wrap;
            if (wrap) begin
                st_d.len  = len_new;
                st_d.acc  = acc_new;
                st_d.rise = rise_pos;
                st_d.fall = fall_pos;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.len  <= LEN_W'(1);
            st_q.acc  <= '0;
            st_q.rise <= '0;
            st_q.fall <= POS_W'(1);
            st_q.lvl  <= 1'b0;
            st_q.stb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_stb = st_q.stb;
    assign pix_clk = st_q.lvl ^ clk_invert;

    a_r5_stb_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wrap) |=> pix_stb);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!pix_stb && $stable(st_q.lvl) && $stable(st_q.cnt)));

    a_r8_shadow_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && wrap) |=> ($stable(st_q.rise) && $stable(st_q.fall) && $stable(st_q.len)));

    a_r3_idx_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.cnt} < st_q.len));

    a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.len != '0));
endmodule

// File: tb/test_pclk_frac_gen.sv
module test_pclk_frac_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        int_tick, ext_tick, src_ext_sel, clk_invert;
    logic [11:0] div_word;
    logic [8:0]  rise_pos, fall_pos;
    logic        pix_stb, pix_clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_run, m_k, m_len, m_fsum, m_rise, m_fall;
    bit m_lvl, m_stb;

    always #2.5 clk = ~clk;

    pclk_frac_gen i_pclk_frac_gen (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
        .src_ext_sel(src_ext_sel), .clk_invert(clk_invert), .div_word(div_word),
        .rise_pos(rise_pos), .fall_pos(fall_pos), .pix_stb(pix_stb), .pix_clk(pix_clk)
    );

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic model_step();
        int ip, f, nf;
        ip = int'(div_word[11:4]);
        if (ip == 0) ip = 1;
        f = int'(div_word[3:0]);
        if (m_run == 0 || m_k == m_len - 1) begin
            nf     = m_fsum + f;
            m_len  = ip + (nf / 16) - (m_fsum / 16);
            m_fsum = nf;
            m_k    = 0;
            m_stb  = 1'b1;
            m_rise = int'(rise_pos);
            m_fall = int'(fall_pos);
            m_run  = 1;
        end else begin
            m_k++;
            m_stb = 1'b0;
        end
        m_lvl = (2 * m_k >= m_rise) && (2 * m_k < m_fall);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; int_tick = 1'b0; ext_tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 stb in reset", pix_stb, 1'b0);
        check("R1 pin in reset", pix_clk, clk_invert);
        rst_n = 1'b1;
        m_run = 0; m_k = 0; m_len = 1; m_fsum = 0; m_lvl = 1'b0; m_stb = 1'b0;
        m_rise = 0; m_fall = 1;
    endtask

    task automatic run(int cycles, int iper, int eper, string tag);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (src_ext_sel ? ext_tick : int_tick) model_step();
            else m_stb = 1'b0;
            check({"R5 strobe ", tag}, pix_stb, m_stb);
            check({"R6 level ", tag}, pix_clk, m_lvl ^ clk_invert);
            int_tick = (iper > 0) && (c % iper == 0);
            ext_tick = (eper > 0) && (c % eper == 0);
        end
    endtask

    task automatic setup(logic [11:0] d, int r, int f);
        div_word = d; rise_pos = 9'(r); fall_pos = 9'(f);
    endtask

    initial begin
        src_ext_sel = 1'b0; clk_invert = 1'b0;
        setup(12'h010, 0, 1);
        do_reset();
        @(negedge clk);
        check("R1 stb after reset", pix_stb, 1'b0);
        check("R1 pin after reset", pix_clk, 1'b0);

        // R3 R7: sweep integer and fraction with 50% edges
        foreach (int_l[i]) begin
            foreach (frac_l[j]) begin
                setup(12'((int_l[i] << 4) | frac_l[j]), 0, int_l[i]);
                do_reset();
                run(34 * (int_l[i] + 1) + 8, 1, 0, "R3 R7");
            end
        end

        // R4: integer part zero acts as one
        setup(12'h000, 0, 1); do_reset(); run(40, 1, 0, "R4");
        setup(12'h007, 0, 1); do_reset(); run(60, 1, 0, "R4");

        // R6: odd positions, rise after fall, always high
        setup(12'h090, 3, 11);  do_reset(); run(60, 1, 0, "R6 odd");
        setup(12'h068, 12, 4);  do_reset(); run(50, 1, 0, "R6 empty");
        setup(12'h050, 0, 511); do_reset(); run(40, 1, 0, "R6 full");
        setup(12'h0A3, 5, 14);  do_reset(); run(90, 2, 0, "R6 sparse");

        // R2: source selection
        setup(12'h034, 0, 3);
        src_ext_sel = 1'b1; do_reset(); run(120, 1, 3, "R2 ext");
        src_ext_sel = 1'b0; do_reset(); run(120, 2, 1, "R2 int");
        src_ext_sel = 1'b1; run(60, 1, 0, "R2 idle ext");
        src_ext_sel = 1'b0;

        // R10: no ticks at all
        setup(12'h040, 0, 4); do_reset(); run(10, 1, 0, "R10"); run(30, 0, 1, "R10");

        // R8: change mid-period
        setup(12'h050, 0, 5); do_reset(); run(7, 1, 0, "R8");
        setup(12'h02A, 1, 3); run(80, 1, 0, "R8");
        setup(12'h0B0, 6, 20); run(4, 1, 0, "R8");
        setup(12'h011, 0, 2); run(60, 1, 0, "R8");

        // R9: polarity inversion
        setup(12'h048, 0, 4); do_reset();
        clk_invert = 1'b1; run(40, 1, 0, "R9");
        clk_invert = 1'b0; run(20, 1, 0, "R9");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    int int_l[4]  = '{1, 2, 3, 7};
    int frac_l[4] = '{0, 5, 8, 15};

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule